// File: doc/BRIEF.md
# Touch Coordinate Sampler

This block polls a resistive touch-screen controller over a byte-oriented SPI master. A poll timer counts out a programmable interval in system clocks. At the end of each interval the block looks at the active-low pen input. If the pen is down, the block opens one chip-select window and runs a fixed six-byte exchange. The exchange is an X-axis command byte followed by two readback bytes, then a Y-axis command byte followed by two more readback bytes. A short settling pause sits between the X readback and the Y command. When the window closes, the two 16-bit readbacks are reduced to 12-bit coordinates. Both coordinates are then published at once with a single-cycle strobe.

The block never shifts bits itself. For each byte it raises a one-cycle start request with the byte to send. It then waits for the SPI master's done flag, which comes with the byte that was received. Calibration, filtering and mapping to screen pixels belong to later logic.

Top module: `touch_sampler`

## Requirements
- R1: While reset is held and right after it, `cs_n` is 1, `spi_start` is 0 and `coord_valid` is 0.
- R2: A sequence starts only at a pen check where `pen_n` is sampled 0. If `pen_n` is 1 at a check, or is low only between checks, `cs_n` stays 1 and no start is issued.
- R3: Pen checks happen every `POLL_CYCLES` clock cycles. The first check is `POLL_CYCLES` cycles after reset is released. After a check with the pen up, or after a finished sequence, the next check is a full `POLL_CYCLES` cycles later.
- R4: `cs_n` falls one cycle before the first `spi_start`. It stays 0 for all six transfers and returns to 1 in the cycle right after the sixth done is sampled.
- R5: The transmitted bytes, in order, are 0xD0 (X command), 0x00, 0x00, 0x90 (Y command), 0x00, 0x00. The command bytes are set by `CMD_X` and `CMD_Y`, and 0x00 is sent while reading.
- R6: `spi_start` is a one-cycle pulse with `spi_tx_byte` valid. No further start is issued until `spi_done` has been sampled high for the current transfer.
- R7: For each axis, the first readback byte is the high byte (hi) and the second is the low byte (lo). The coordinate is ({hi,lo} >> 3) truncated to 12 bits, so it equals {hi[6:0], lo[7:3]}.
- R8: After the third done (the X low byte), the next start comes exactly `SETTLE_CYCLES` cycles later. After every other done that is followed by a transfer, the next start comes in the very next cycle.
- R9: `x_coord` and `y_coord` change together, only in the cycle where `coord_valid` is 1. `coord_valid` is a one-cycle pulse that coincides with `cs_n` returning high, and it stays 0 at all other times.
- R10: If `pen_n` goes high during a sequence, the sequence still runs all six transfers, releases `cs_n` normally and publishes coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pen_n | input | 1 | Pen-down indication, active low, synchronous to clk |
| spi_start | output | 1 | One-cycle request to the SPI master to exchange one byte |
| spi_tx_byte | output | 8 | Byte to send, valid with `spi_start` and held during the transfer |
| spi_done | input | 1 | One-cycle completion flag from the SPI master |
| spi_rx_byte | input | 8 | Byte received, valid with `spi_done` |
| cs_n | output | 1 | Chip select to the touch controller, active low |
| x_coord | output | 12 | Latest X coordinate |
| y_coord | output | 12 | Latest Y coordinate |
| coord_valid | output | 1 | One-cycle strobe when both coordinates are updated |

## Verification
The assertions assume that the SPI master raises `spi_done` only while a transfer it was asked for is still open. They also assume `spi_done` lasts one cycle and that `pen_n` is already synchronous to `clk`. The bench enforces both. Its SPI model answers a start only after at least one idle cycle, drives done for exactly one cycle, and keeps done low at every other time. It changes `pen_n` only on falling clock edges.

// File: rtl/touch_pkg.sv
package touch_pkg;

  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 2 * BYTE_W;
  localparam int COORD_W   = 12;
  localparam int DROP_BITS = 3;
  localparam int STEP_W    = 3;

  // Fixed order of the six byte transfers inside one chip-select window
  localparam logic [STEP_W-1:0] STEP_X_CMD = 3'd0;
  localparam logic [STEP_W-1:0] STEP_X_HI  = 3'd1;
  localparam logic [STEP_W-1:0] STEP_X_LO  = 3'd2;
  localparam logic [STEP_W-1:0] STEP_Y_CMD = 3'd3;
  localparam logic [STEP_W-1:0] STEP_Y_HI  = 3'd4;
  localparam logic [STEP_W-1:0] STEP_Y_LO  = 3'd5;

  typedef enum logic [2:0] {
    ST_POLL,
    ST_SELECT,
    ST_REQ,
    ST_WAIT,
    ST_SETTLE
  } seq_state_t;

  // Join the two readback bytes and drop the low padding bits
  function automatic logic [COORD_W-1:0] pack_coord(
    input logic [BYTE_W-1:0] hi,
    input logic [BYTE_W-1:0] lo
  );
    logic [WORD_W-1:0] word;
    word = {hi, lo} >> DROP_BITS;
    return word[COORD_W-1:0];
  endfunction

  // Byte driven towards the controller for a given step
  function automatic logic [BYTE_W-1:0] step_tx(
    input logic [STEP_W-1:0] step,
    input logic [BYTE_W-1:0] cmd_x,
    input logic [BYTE_W-1:0] cmd_y
  );
    case (step)
      STEP_X_CMD: return cmd_x;
      STEP_Y_CMD: return cmd_y;
      default:    return '0;
    endcase
  endfunction

endpackage

// File: rtl/ts_countdown.sv
module ts_countdown #(
  parameter int unsigned SPAN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic tick,
  output logic expired
);

  localparam int unsigned CW = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam logic [CW-1:0] TOP = CW'(SPAN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= TOP;
    end else if (reload) begin
      cnt <= TOP;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/ts_coord_pack.sv
module ts_coord_pack
  import touch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_done,
  input  logic [STEP_W-1:0]    step,
  input  logic [BYTE_W-1:0]    rx_byte,
  output logic [COORD_W-1:0]   x_coord,
  output logic [COORD_W-1:0]   y_coord,
  output logic                 coord_valid
);

  logic [BYTE_W-1:0]  x_hi_q;
  logic [BYTE_W-1:0]  y_hi_q;
  logic [COORD_W-1:0] x_pend_q;

  logic take_x_hi;
  logic take_x_lo;
  logic take_y_hi;
  logic take_y_lo;

  assign take_x_hi = byte_done && (step == STEP_X_HI);
  assign take_x_lo = byte_done && (step == STEP_X_LO);
  assign take_y_hi = byte_done && (step == STEP_Y_HI);
  assign take_y_lo = byte_done && (step == STEP_Y_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_hi_q   <= '0;
      y_hi_q   <= '0;
      x_pend_q <= '0;
    end else begin
      if (take_x_hi) x_hi_q   <= rx_byte;
      if (take_x_lo) x_pend_q <= pack_coord(x_hi_q, rx_byte);
      if (take_y_hi) y_hi_q   <= rx_byte;
    end
  end

  // Both axes are published in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_coord     <= '0;
      y_coord     <= '0;
      coord_valid <= 1'b0;
    end else begin
      coord_valid <= take_y_lo;
      if (take_y_lo) begin
        x_coord <= x_pend_q;
        y_coord <= pack_coord(y_hi_q, rx_byte);
      end
    end
  end

endmodule

// File: rtl/touch_sampler.sv
module touch_sampler
  import touch_pkg::*;
#(
  parameter int unsigned POLL_CYCLES   = 50_000_000,
  parameter int unsigned SETTLE_CYCLES = 1_000,
  parameter logic [7:0]  CMD_X         = 8'hD0,
  parameter logic [7:0]  CMD_Y         = 8'h90
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pen_n,
  output logic        spi_start,
  output logic [7:0]  spi_tx_byte,
  input  logic        spi_done,
  input  logic [7:0]  spi_rx_byte,
  output logic        cs_n,
  output logic [11:0] x_coord,
  output logic [11:0] y_coord,
  output logic        coord_valid
);

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              cs_n_q;

  // Named internal events
  logic poll_expired;
  logic settle_expired;
  logic check_now;
  logic seq_begin;
  logic byte_done;
  logic settle_begin;
  logic last_byte_done;
  logic xfer_busy;
  logic poll_reload;

  assign check_now      = (state_q == ST_POLL) && poll_expired;
  assign seq_begin      = check_now && !pen_n;
  assign byte_done      = (state_q == ST_WAIT) && spi_done;
  assign settle_begin   = byte_done && (step_q == STEP_X_LO);
  assign last_byte_done = byte_done && (step_q == STEP_Y_LO);
  assign xfer_busy      = (state_q == ST_WAIT);
  assign poll_reload    = (check_now && pen_n) || last_byte_done;

  ts_countdown #(.SPAN(POLL_CYCLES)) poll_tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (poll_reload),
    .tick    (state_q == ST_POLL),
    .expired (poll_expired)
  );

  ts_countdown #(.SPAN(SETTLE_CYCLES)) settle_tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (settle_begin),
    .tick    (state_q == ST_SETTLE),
    .expired (settle_expired)
  );

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      ST_POLL: begin
        if (seq_begin) begin
          state_d = ST_SELECT;
          step_d  = STEP_X_CMD;
        end
      end
      ST_SELECT: state_d = ST_REQ;
      ST_REQ:    state_d = ST_WAIT;
      ST_WAIT: begin
        if (byte_done) begin
          if (last_byte_done) begin
            state_d = ST_POLL;
            step_d  = STEP_X_CMD;
          end else if (settle_begin) begin
            state_d = ST_SETTLE;
            step_d  = step_q + 1'b1;
          end else begin
            state_d = ST_REQ;
            step_d  = step_q + 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (settle_expired) state_d = ST_REQ;
      end
      default: state_d = ST_POLL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_POLL;
      step_q  <= STEP_X_CMD;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (seq_begin)           cs_n_q <= 1'b0;
      else if (last_byte_done) cs_n_q <= 1'b1;
    end
  end

  assign cs_n        = cs_n_q;
  assign spi_start   = (state_q == ST_REQ);
  assign spi_tx_byte = step_tx(step_q, CMD_X, CMD_Y);

  ts_coord_pack pack_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_done   (byte_done),
    .step        (step_q),
    .rx_byte     (spi_rx_byte),
    .x_coord     (x_coord),
    .y_coord     (y_coord),
    .coord_valid (coord_valid)
  );

endmodule

// File: rtl/touch_sampler_chk.sv
module touch_sampler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pen_n,
  input logic        cs_n,
  input logic        spi_start,
  input logic        spi_done,
  input logic        xfer_busy,
  input logic        coord_valid,
  input logic [11:0] x_coord,
  input logic [11:0] y_coord
);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start);

  // R6
  no_start_while_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !spi_done) |=> !spi_start);

  // R4
  start_under_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !cs_n);

  // R4
  select_leads_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> spi_start == 1'b0 ##1 spi_start);

  // R2
  begin_needs_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(pen_n));

  // R9
  valid_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coord_valid |-> $rose(cs_n));

  // R9
  coords_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coord_valid |=> (coord_valid || ($stable(x_coord) && $stable(y_coord))));

endmodule

bind touch_sampler touch_sampler_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pen_n       (pen_n),
  .cs_n        (cs_n),
  .spi_start   (spi_start),
  .spi_done    (spi_done),
  .xfer_busy   (xfer_busy),
  .coord_valid (coord_valid),
  .x_coord     (x_coord),
  .y_coord     (y_coord)
);

// File: tb/touch_sampler_tb.sv
module touch_sampler_tb_top;

  localparam int POLL   = 40;
  localparam int SETTLE = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pen_n;
  logic        spi_start;
  logic [7:0]  spi_tx_byte;
  logic        spi_done;
  logic [7:0]  spi_rx_byte;
  logic        cs_n;
  logic [11:0] x_coord;
  logic [11:0] y_coord;
  logic        coord_valid;

  longint cyc;
  int     checks   = 0;
  int     failures = 0;
  bit     finished = 1'b0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  touch_sampler #(
    .POLL_CYCLES   (POLL),
    .SETTLE_CYCLES (SETTLE)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pen_n       (pen_n),
    .spi_start   (spi_start),
    .spi_tx_byte (spi_tx_byte),
    .spi_done    (spi_done),
    .spi_rx_byte (spi_rx_byte),
    .cs_n        (cs_n),
    .x_coord     (x_coord),
    .y_coord     (y_coord),
    .coord_valid (coord_valid)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_coord(input int hi, input int lo);
    return ((hi * 256 + lo) / 8) % 4096;
  endfunction

  // One byte transfer as seen by a well-behaved SPI master
  task automatic serve(input int exp_tx, input int rx, input int lat,
                       output longint st_cyc, output longint dn_cyc);
    while (spi_start !== 1'b1) @(negedge clk);
    st_cyc = cyc;
    chk("R5 transmitted byte", spi_tx_byte, exp_tx);
    chk("R4 select low during transfer", cs_n, 0);
    @(negedge clk);
    chk("R6 start lasts one cycle", spi_start, 0);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R6 no new start before done", spi_start, 0);
      chk("R9 no strobe mid-sequence", coord_valid, 0);
    end
    spi_rx_byte = 8'(rx);
    spi_done    = 1'b1;
    @(negedge clk);
    spi_done    = 1'b0;
    spi_rx_byte = 8'h00;
    dn_cyc = cyc;
  endtask

  task automatic run_seq(input int xh, input int xl, input int yh, input int yl,
                         input int lat, input bit raise_mid,
                         output longint cs_cyc, output longint val_cyc);
    longint st[6];
    longint dn[6];
    int tx_exp[6];
    int rx_val[6];
    logic [11:0] xs, ys;
    tx_exp = '{8'hD0, 0, 0, 8'h90, 0, 0};
    rx_val = '{0, xh, xl, 0, yh, yl};
    while (cs_n !== 1'b0) @(negedge clk);
    cs_cyc = cyc;
    for (int b = 0; b < 6; b++) begin
      serve(tx_exp[b], rx_val[b], lat, st[b], dn[b]);
      if (raise_mid && b == 1) pen_n = 1'b1;
    end
    val_cyc = cyc;
    chk("R9 strobe with release", coord_valid, 1);
    chk("R4 select released after sixth done", cs_n, 1);
    chk("R7 X coordinate", x_coord, expect_coord(xh, xl));
    chk("R7 Y coordinate", y_coord, expect_coord(yh, yl));
    chk("R4 select leads first start by one cycle", st[0] - cs_cyc, 1);
    chk("R8 settle gap after X low byte", st[3] - dn[2], SETTLE);
    chk("R8 no gap after X command", st[1] - dn[0], 0);
    chk("R8 no gap after Y high byte", st[5] - dn[4], 0);
    xs = x_coord;
    ys = y_coord;
    @(negedge clk);
    chk("R9 strobe one cycle", coord_valid, 0);
    chk("R9 X held", x_coord, xs);
    chk("R9 Y held", y_coord, ys);
  endtask

  initial begin
    longint cs_c, val_c, prev_val;
    int falls;
    rst_n       = 1'b0;
    pen_n       = 1'b1;
    spi_done    = 1'b0;
    spi_rx_byte = 8'h00;
    repeat (5) @(negedge clk);
    chk("R1 select idle in reset", cs_n, 1);
    chk("R1 no start in reset", spi_start, 0);
    chk("R1 no strobe in reset", coord_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 select idle after reset", cs_n, 1);
    chk("R1 strobe low after reset", coord_valid, 0);

    // R2: pen up across three checks
    falls = 0;
    repeat (3 * POLL + 5) begin
      @(negedge clk);
      if (cs_n == 1'b0 || spi_start == 1'b1) falls++;
    end
    chk("R2 no sequence with pen up", falls, 0);

    pen_n = 1'b0;
    run_seq(8'h00, 8'h00, 8'h00, 8'h00, 1, 1'b0, cs_c, val_c);
    chk("R3 first checks on interval grid", cs_c % POLL, 0);
    prev_val = val_c;

    // Sweep of readback patterns and master latencies
    for (int i = 0; i < 10; i++) begin
      int xh, xl, yh, yl;
      if (i == 0) begin
        xh = 255; xl = 255; yh = 255; yl = 255;
      end else begin
        xh = (i * 53 + 7) % 256;
        xl = (i * 29 + 200) % 256;
        yh = (255 - i * 17) % 256;
        yl = (i * 91) % 256;
      end
      run_seq(xh, xl, yh, yl, 1 + (i % 3), 1'b0, cs_c, val_c);
      chk("R3 interval after sequence", cs_c - prev_val, POLL);
      prev_val = val_c;
    end

    // R10: pen lifts mid-sequence
    run_seq(8'h12, 8'h34, 8'hAB, 8'hCD, 2, 1'b1, cs_c, val_c);
    chk("R10 sequence completes after pen lift", cs_c - prev_val, POLL);
    prev_val = val_c;

    // R2: short pen dip between checks is ignored
    falls = 0;
    while (cyc < prev_val + POLL / 2) @(negedge clk);
    pen_n = 1'b0;
    repeat (3) @(negedge clk);
    pen_n = 1'b1;
    while (cyc < prev_val + 2 * POLL + 3) begin
      @(negedge clk);
      if (cs_n == 1'b0) falls++;
    end
    chk("R2 dip between checks ignored", falls, 0);

    pen_n = 1'b0;
    run_seq(8'h7F, 8'hF8, 8'h80, 8'h07, 3, 1'b0, cs_c, val_c);
    chk("R3 pen-up check reloads full interval", (cs_c - prev_val) % POLL, 0);
    chk("R3 later check used", cs_c - prev_val, 3 * POLL);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule